// File: doc/BRIEF.md
# Bitmap display fetch address generator

This block generates the memory word addresses that a planar bitmap display uses to refresh the screen. It holds a word-aligned base address and a refresh address counter, and both can be written. At each frame start the counter is reloaded from the base. At each line start the block issues a burst of word fetch requests, one per clock, at consecutive counter addresses. At each line end it adds a programmable line offset in words to the counter, so that the visible window can sit inside a virtual screen wider than the display.

A four-bit fine horizontal scroll value is captured at line start and presented to the pixel path as a bit-shift amount. Whenever this value is nonzero, the burst contains one extra fetch group, because pixels shifted off the left edge must be refilled on the right. The line offset is defined net of that extra group, so software lowers it by one group while scrolling. In four-plane low resolution one group is four words. In single-plane monochrome one group is one word. Vertical scrolling is done by writing a new base, which takes effect at the next frame start.

Top module: `vfa_top`

## Requirements
- R1: After reset, fetch_req is 0, fetch_addr (the counter) is 0 and pix_shift is 0.
- R2: A frame_start pulse with no counter write in the same cycle loads the counter from the base register, and fetch_addr shows it on the following cycle. Any burst in progress is stopped.
- R3: A line_start pulse starts a burst. From the next cycle, fetch_req stays 1 for exactly the line's word count, and fetch_addr rises by one word on each request cycle. With res_mode=0 (low resolution) and hscroll=0, the burst is 80 words (20 groups of four).
- R4: With res_mode=0 and hscroll nonzero, the burst is 84 words (21 groups of four).
- R5: A line_end pulse outside a burst adds line_offset (in words, zero-extended) to the counter. An offset of 0 leaves consecutive lines contiguous. With three 80-word images side by side, an offset of 160 with no scroll and 156 with scroll both advance each line by 240 words.
- R6: A cnt_wr pulse loads cnt_wdata into the counter in the next cycle, at any time, even during a burst. It has priority over frame_start, increments and line_end. During a burst, the next request uses the written address, and the burst length does not change.
- R7: A base_wr pulse changes only the base register. The counter is unaffected until the next frame_start.
- R8: pix_shift takes the value of hscroll at line_start and holds it until the next line_start, whatever hscroll does meanwhile.
- R9: With res_mode=1 (monochrome, one-word groups), the burst is 40 words for hscroll=0 and 41 words for hscroll nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_mode | input | 1 | 0 = four-plane low resolution, 1 = single-plane monochrome; sampled at line_start |
| hscroll | input | 4 | Fine horizontal scroll in bits, sampled at line_start |
| line_offset | input | OFS_W | Words added to the counter at line_end |
| base_wr | input | 1 | Write strobe for the base register |
| base_wdata | input | WA_W | New base word address |
| cnt_wr | input | 1 | Write strobe for the refresh counter |
| cnt_wdata | input | WA_W | New counter word address |
| frame_start | input | 1 | Frame start pulse |
| line_start | input | 1 | Active line start pulse |
| line_end | input | 1 | Line end pulse |
| fetch_req | output | 1 | A word fetch is requested this cycle |
| fetch_addr | output | WA_W | Refresh counter; the fetch word address when fetch_req is 1 |
| pix_shift | output | 4 | Bit-shift amount for the current line |

## Verification
The assertions rely on the timing source sending line_start and line_end only when no burst is running, and line_end only after the burst for that line has finished. The counter-add check holds only in cycles without a simultaneous counter write or frame start. The bench's stimulus follows this rule. It lets every burst drain before it pulses line_end, and it never pulses line_start during a burst. Random counter writes, base writes and scroll changes are placed freely, including in the middle of bursts, because the design defines their effect at every cycle.

// File: rtl/vfa_pkg.sv
package vfa_pkg;

    localparam int unsigned LO_WORDS_PER_GROUP   = 4;
    localparam int unsigned MONO_WORDS_PER_GROUP = 1;

    typedef enum logic {
        RES_LOW  = 1'b0,
        RES_MONO = 1'b1
    } res_e;

    typedef struct packed {
        logic wr;     // software counter write
        logic fs;     // frame start reload
        logic inc;    // one word fetched
        logic add;    // end-of-line offset
    } cnt_ctl_t;

    function automatic int unsigned line_words(
        input res_e        res,
        input logic        scroll_on,
        input int unsigned lo_groups,
        input int unsigned mono_groups
    );
        int unsigned grp;
        grp = (res == RES_MONO) ? mono_groups : lo_groups;
        if (scroll_on) grp = grp + 1;
        return (res == RES_MONO) ? grp * MONO_WORDS_PER_GROUP
                                 : grp * LO_WORDS_PER_GROUP;
    endfunction

    function automatic int unsigned max_words(
        input int unsigned lo_groups,
        input int unsigned mono_groups
    );
        int unsigned a;
        int unsigned b;
        a = (lo_groups + 1) * LO_WORDS_PER_GROUP;
        b = (mono_groups + 1) * MONO_WORDS_PER_GROUP;
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vfa_line_seq.sv
module vfa_line_seq
    import vfa_pkg::*;
#(
    parameter int unsigned LO_GROUPS   = 20,
    parameter int unsigned MONO_GROUPS = 40,
    localparam int unsigned MAXW       = max_words(LO_GROUPS, MONO_GROUPS),
    localparam int unsigned LEFT_W     = $clog2(MAXW + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start,
    input  logic       frame_start,
    input  res_e       res,
    input  logic [3:0] hscroll,
    output logic       busy,
    output logic [3:0] shift
);

    logic [LEFT_W-1:0] left_q;
    logic [3:0]        shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            shift_q <= '0;
        end else begin
            if (line_start) shift_q <= hscroll;
            if (frame_start)
                left_q <= '0;
            else if (line_start)
                left_q <= LEFT_W'(line_words(res, hscroll != 4'd0,
                                             LO_GROUPS, MONO_GROUPS));
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    assign busy  = (left_q != '0);
    assign shift = shift_q;

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(shift_q)); // R8

    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(left_q) <= MAXW); // R4

    AST_FRAME_STOP: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !busy); // R2

endmodule

// File: rtl/vfa_addr_cnt.sv
module vfa_addr_cnt
    import vfa_pkg::*;
#(
    parameter int unsigned WA_W  = 23,
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_wr,
    input  logic [WA_W-1:0]  base_wdata,
    input  logic [WA_W-1:0]  cnt_wdata,
    input  logic [OFS_W-1:0] line_offset,
    input  cnt_ctl_t         ctl,
    output logic [WA_W-1:0]  cnt
);

    logic [WA_W-1:0] base_q;
    logic [WA_W-1:0] cnt_q;
    logic [WA_W-1:0] ofs_ext;

    assign ofs_ext = {{(WA_W-OFS_W){1'b0}}, line_offset};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (base_wr) base_q <= base_wdata;
            if (ctl.wr)
                cnt_q <= cnt_wdata;
            else if (ctl.fs)
                cnt_q <= base_q;
            else if (ctl.inc)
                cnt_q <= cnt_q + 1'b1;
            else if (ctl.add)
                cnt_q <= cnt_q + ofs_ext;
        end
    end

    assign cnt = cnt_q;

    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |=> cnt_q == $past(cnt_wdata)); // R6

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ctl.fs && !ctl.wr) |=> cnt_q == $past(base_q)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.wr && !ctl.fs && !ctl.inc && !ctl.add) |=> $stable(cnt_q)); // R7

    AST_LINE_ADD: assert property (@(posedge clk) disable iff (rst)
        (ctl.add && !ctl.wr && !ctl.fs && !ctl.inc)
        |=> cnt_q == $past(cnt_q) + {{(WA_W-OFS_W){1'b0}}, $past(line_offset)}); // R5

endmodule

// File: rtl/vfa_top.sv
module vfa_top
    import vfa_pkg::*;
#(
    parameter int unsigned WA_W        = 23,
    parameter int unsigned OFS_W       = 8,
    parameter int unsigned LO_GROUPS   = 20,
    parameter int unsigned MONO_GROUPS = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_mode,
    input  logic [3:0]       hscroll,
    input  logic [OFS_W-1:0] line_offset,
    input  logic             base_wr,
    input  logic [WA_W-1:0]  base_wdata,
    input  logic             cnt_wr,
    input  logic [WA_W-1:0]  cnt_wdata,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             line_end,
    output logic             fetch_req,
    output logic [WA_W-1:0]  fetch_addr,
    output logic [3:0]       pix_shift
);

    logic     busy;
    cnt_ctl_t ctl;
    res_e     res;

    assign res = res_e'(res_mode);

    vfa_line_seq #(
        .LO_GROUPS   (LO_GROUPS),
        .MONO_GROUPS (MONO_GROUPS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .frame_start (frame_start),
        .res         (res),
        .hscroll     (hscroll),
        .busy        (busy),
        .shift       (pix_shift)
    );

    always_comb begin
        ctl.wr  = cnt_wr;
        ctl.fs  = frame_start;
        ctl.inc = busy;
        ctl.add = line_end;
    end

    vfa_addr_cnt #(
        .WA_W  (WA_W),
        .OFS_W (OFS_W)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .base_wr     (base_wr),
        .base_wdata  (base_wdata),
        .cnt_wdata   (cnt_wdata),
        .line_offset (line_offset),
        .ctl         (ctl),
        .cnt         (fetch_addr)
    );

    assign fetch_req = busy;

    AST_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !cnt_wr && !frame_start)
        |=> (!fetch_req || fetch_addr == $past(fetch_addr) + 1'b1)); // R3

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (!fetch_req && fetch_addr == '0 && pix_shift == 4'd0)); // R1

endmodule

// File: tb/vfa_top_tb.sv
module vfa_top_tb;

    localparam int WA_W  = 23;
    localparam int OFS_W = 8;
    localparam int LO_G  = 20;
    localparam int MO_G  = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             res_mode = 1'b0;
    logic [3:0]       hscroll = '0;
    logic [OFS_W-1:0] line_offset = '0;
    logic             base_wr = 1'b0;
    logic [WA_W-1:0]  base_wdata = '0;
    logic             cnt_wr = 1'b0;
    logic [WA_W-1:0]  cnt_wdata = '0;
    logic             frame_start = 1'b0;
    logic             line_start = 1'b0;
    logic             line_end = 1'b0;
    logic             fetch_req;
    logic [WA_W-1:0]  fetch_addr;
    logic [3:0]       pix_shift;

    int n_vec  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [WA_W-1:0] exp_cnt  = '0;
    logic [WA_W-1:0] exp_base = '0;

    always #5 clk = ~clk;

    vfa_top #(.WA_W(WA_W), .OFS_W(OFS_W), .LO_GROUPS(LO_G), .MONO_GROUPS(MO_G)) u_dut (
        .clk(clk), .rst(rst), .res_mode(res_mode), .hscroll(hscroll),
        .line_offset(line_offset), .base_wr(base_wr), .base_wdata(base_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .frame_start(frame_start),
        .line_start(line_start), .line_end(line_end), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .pix_shift(pix_shift)
    );

    function automatic int exp_words(input logic mono, input logic [3:0] hs);
        int g;
        g = mono ? MO_G : LO_G;
        if (hs != 4'd0) g = g + 1;
        return mono ? g : g * 4;
    endfunction

    task automatic chk(input string req, input longint act, input longint expv);
        n_vec++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        exp_cnt = exp_base;
        chk("R2 frame reload", fetch_addr, exp_cnt);
        chk("R2 idle after frame", fetch_req, 0);
    endtask

    task automatic do_base(input logic [WA_W-1:0] v);
        base_wr = 1'b1;
        base_wdata = v;
        @(negedge clk);
        base_wr = 1'b0;
        exp_base = v;
        chk("R7 counter kept on base write", fetch_addr, exp_cnt);
    endtask

    task automatic do_cnt_wr(input logic [WA_W-1:0] v);
        cnt_wr = 1'b1;
        cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
        exp_cnt = v;
        chk("R6 idle counter write", fetch_addr, exp_cnt);
    endtask

    task automatic do_line(input logic mono, input logic [3:0] hs,
                           input int wr_at, input logic [WA_W-1:0] wr_data);
        int n;
        string rq;
        rq = mono ? "R9 burst length" : ((hs != 0) ? "R4 burst length" : "R3 burst length");
        res_mode = mono;
        hscroll = hs;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        n = 0;
        while (fetch_req === 1'b1 && n < 200) begin
            if (n == 1) hscroll = hs ^ 4'hF;
            chk("R3 fetch address", fetch_addr, exp_cnt);
            chk("R8 shift held", pix_shift, hs);
            if (n == wr_at) begin
                cnt_wr = 1'b1;
                cnt_wdata = wr_data;
                exp_cnt = wr_data;
            end else begin
                exp_cnt = exp_cnt + 1'b1;
            end
            n++;
            @(negedge clk);
            cnt_wr = 1'b0;
        end
        chk(rq, n, exp_words(mono, hs));
        chk("R3 counter after burst", fetch_addr, exp_cnt);
    endtask

    task automatic do_end(input logic [OFS_W-1:0] ofs);
        line_offset = ofs;
        line_end = 1'b1;
        @(negedge clk);
        line_end = 1'b0;
        exp_cnt = exp_cnt + {{(WA_W-OFS_W){1'b0}}, ofs};
        chk("R5 offset add", fetch_addr, exp_cnt);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [WA_W-1:0] start;
        int unsigned r;
        r = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset req", fetch_req, 0);
        chk("R1 reset addr", fetch_addr, 0);
        chk("R1 reset shift", pix_shift, 0);

        // R7 base write leaves counter, R2 frame loads it
        do_base(23'h012340);
        chk("R7 counter still zero", fetch_addr, 0);
        do_frame();

        // R3 plain low-res line, R5 zero offset
        do_line(1'b0, 4'd0, -1, '0);
        do_end(8'd0);
        // R4 scrolled low-res line
        do_line(1'b0, 4'd7, -1, '0);
        do_end(8'd0);
        // R9 monochrome both ways
        do_line(1'b1, 4'd0, -1, '0);
        do_end(8'd3);
        do_line(1'b1, 4'd15, -1, '0);
        do_end(8'd0);

        // R5 three images side by side: stride 240 words either way
        start = fetch_addr;
        do_line(1'b0, 4'd0, -1, '0);
        do_end(8'd160);
        chk("R5 stride no scroll", fetch_addr - start, 240);
        start = fetch_addr;
        do_line(1'b0, 4'd9, -1, '0);
        do_end(8'd156);
        chk("R5 stride with scroll", fetch_addr - start, 240);

        // R6 mid-burst counter write, including on the last word
        do_line(1'b0, 4'd0, 10, 23'h055500);
        do_end(8'd0);
        do_line(1'b1, 4'd1, 40, 23'h000777);
        do_cnt_wr(23'h100000);

        // R7 base write mid-frame then R2 reload
        do_base(23'h7FFF00);
        do_line(1'b0, 4'd0, -1, '0);
        do_end(8'd255);
        do_frame();

        // random lines
        for (int i = 0; i < 40; i++) begin
            logic mono;
            logic [3:0] hs;
            int wa;
            mono = 1'($urandom);
            hs = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
            wa = ($urandom % 4 == 0) ? int'($urandom % 40) : -1;
            do_line(mono, hs, wa, WA_W'($urandom));
            do_end(OFS_W'($urandom));
            if ($urandom % 5 == 0) do_base(WA_W'($urandom));
            if ($urandom % 6 == 0) do_cnt_wr(WA_W'($urandom));
            if (i % 8 == 7) do_frame();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule